// File: doc/BRIEF.md
# Clock Output Stop and Enable Gating

This block sits between the clock sources of a system clock generator and its output pins. It takes five source clocks (processor, SDRAM, PCI, reference and a 48 MHz peripheral clock) and drives every output of each group through its own gate. An output runs only when its own enable bit is set, the power-down input is high and, unless it is the free-running output of its group, the group's stop input is high. A register-held output rests at logic low.

Every control input is treated as asynchronous. Each output takes the control level into its own source clock domain through a short synchroniser. The gate then changes only while the source clock is low, so a stop or a start never makes a shortened pulse. One peripheral output can run at the 48 MHz source rate or at half that rate. The switch between those rates is timed so that it also makes no runt pulse. A separate high-impedance request clears the shared output-enable line. It takes effect at once, whatever the gates are doing.

Top module: `clkout_gate`

## Requirements
- R1: While `cpu_stop_ni` is low, processor outputs 1 and 2 stay low. Output 0 is free-running and keeps toggling.
- R2: While `pci_stop_ni` is low, PCI outputs 1 to 6 stay low. Output 0 is free-running and keeps toggling.
- R3: While `sdr_stop_ni` is low, SDRAM outputs 2 to 9 stay low. Outputs 0 and 1 are free-running and keep toggling.
- R4: An output whose enable bit is 0 stays low whatever its stop input does. An output whose bit is 1 toggles at its source rate when nothing else holds it. The reference and peripheral outputs have no stop input.
- R5: While `pd_ni` is low, every clock output stays low, the free-running ones included.
- R6: While `hiz_i` is 1, `clk_oe_o` is 0 in the same instant, whatever the power-down, stop and enable levels are. Otherwise `clk_oe_o` is 1.
- R7: No output ever makes a high pulse shorter than the high phase of its source clock, however the controls change.
- R8: A stop or disable that settles between two source rising edges takes effect from the third of the following rising edges, which makes no pulse. A release makes its first full pulse on that third rising edge.
- R9: Peripheral output bit 1 runs at half the `usb_clk_i` rate when `usb_half_i` is 1, and at the full rate when it is 0. Peripheral bit 0 always runs at the full rate.
- R10: While `rst_ni` is low, every clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Processor group source clock |
| pci_clk_i | input | 1 | PCI group source clock |
| sdr_clk_i | input | 1 | SDRAM group source clock |
| ref_clk_i | input | 1 | Reference group source clock |
| usb_clk_i | input | 1 | 48 MHz peripheral source clock |
| cpu_stop_ni | input | 1 | Processor group stop, active low |
| pci_stop_ni | input | 1 | PCI group stop, active low |
| sdr_stop_ni | input | 1 | SDRAM group stop, active low |
| pd_ni | input | 1 | Asynchronous power-down, active low |
| hiz_i | input | 1 | High-impedance request for all outputs |
| usb_half_i | input | 1 | 1 selects half rate for peripheral bit 1 |
| cpu_en_i | input | 3 | Per-output enables, processor group |
| pci_en_i | input | 7 | Per-output enables, PCI group |
| sdr_en_i | input | 10 | Per-output enables, SDRAM group |
| ref_en_i | input | 2 | Per-output enables, reference group |
| usb_en_i | input | 2 | Per-output enables, peripheral group |
| cpu_clk_o | output | 3 | Gated processor clocks |
| pci_clk_o | output | 7 | Gated PCI clocks |
| sdr_clk_o | output | 10 | Gated SDRAM clocks |
| ref_clk_o | output | 2 | Gated reference clocks |
| usb_clk_o | output | 2 | Gated peripheral clocks |
| clk_oe_o | output | 1 | Output-enable for all clock pins |

## Verification
A gate flop left in the wrong state shows as an output that toggles when it should rest low, or that rests low when it should toggle. This is visible within three source periods of the control change. A synchroniser stage that is missing or doubled moves the first or last pulse by one source edge, which the edge-exact latency test catches. A gate or rate switch updated in the high phase shows up at once as a high pulse narrower than the source high phase. The pulse-width monitor on every output records it.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    // group sizes and free-running output counts (free outputs are the lowest indices)
    localparam int CPU_OUTS   = 3;
    localparam int CPU_FREE   = 1;
    localparam int PCI_OUTS   = 7;
    localparam int PCI_FREE   = 1;
    localparam int SDR_OUTS   = 10;
    localparam int SDR_FREE   = 2;
    localparam int REF_OUTS   = 2;
    localparam int USB_OUTS   = 2;

    // synchroniser depth in every gate cell (at least 2)
    localparam int SYNC_DEPTH = 2;
    localparam int SYNC_MSB   = SYNC_DEPTH - 1;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] chain;
    } cell_rise_t;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] chain;
        logic                  tog;
    } rate_rise_t;

endpackage

// File: rtl/clkout_gate_cell.sv
module clkout_gate_cell
    import clkout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic run_i,
    input  logic safe_i,
    output logic gclk_o
);

    cell_rise_t rise_d, rise_q;
    logic       gate_d, gate_q;

    // rising-edge side: bring the asynchronous run level into this domain
    always_comb begin
        rise_d       = rise_q;
        rise_d.chain = {rise_q.chain[SYNC_DEPTH-2:0], run_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q <= '0;
        else         rise_q <= rise_d;
    end

    // falling-edge side: the gate moves only while the source is low
    always_comb begin
        gate_d = gate_q;
        if (safe_i) gate_d = rise_q.chain[SYNC_MSB];
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end

    assign gclk_o = src_i & gate_q;

endmodule

// File: rtl/clkout_group.sv
module clkout_group
    import clkout_pkg::*;
#(
    parameter int OUTS     = 3,
    parameter int FREE     = 1,
    parameter bit HAS_STOP = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [OUTS-1:0] src_i,
    input  logic [OUTS-1:0] safe_i,
    input  logic [OUTS-1:0] en_i,
    input  logic            stop_ni,
    input  logic            pd_ni,
    output logic [OUTS-1:0] gclk_o
);

    function automatic logic [OUTS-1:0] free_mask();
        logic [OUTS-1:0] m;
        for (int i = 0; i < OUTS; i++) m[i] = !HAS_STOP || (i < FREE);
        return m;
    endfunction

    localparam logic [OUTS-1:0] FREE_MASK = free_mask();

    logic [OUTS-1:0] run;

    for (genvar g = 0; g < OUTS; g++) begin : g_out
        assign run[g] = pd_ni & en_i[g] & (stop_ni | FREE_MASK[g]);

        clkout_gate_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .src_i  (src_i[g]),
            .run_i  (run[g]),
            .safe_i (safe_i[g]),
            .gclk_o (gclk_o[g])
        );
    end

endmodule

// File: rtl/clkout_rate_sel.sv
module clkout_rate_sel
    import clkout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic half_i,
    output logic src_o,
    output logic safe_o
);

    rate_rise_t rise_d, rise_q;
    logic       sel_d, sel_q;

    always_comb begin
        rise_d       = rise_q;
        rise_d.chain = {rise_q.chain[SYNC_DEPTH-2:0], half_i};
        rise_d.tog   = ~rise_q.tog;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rise_q.chain <= '1;
            rise_q.tog   <= 1'b0;
        end else begin
            rise_q <= rise_d;
        end
    end

    // the selection moves on a falling edge where both candidates are low
    always_comb begin
        sel_d = sel_q;
        if (!rise_q.tog) sel_d = rise_q.chain[SYNC_MSB];
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sel_q <= 1'b1;
        else         sel_q <= sel_d;
    end

    assign src_o  = sel_q ? rise_q.tog : clk_i;
    assign safe_o = ~(sel_q & rise_q.tog);

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
    import clkout_pkg::*;
(
    input  logic                rst_ni,
    input  logic                cpu_clk_i,
    input  logic                pci_clk_i,
    input  logic                sdr_clk_i,
    input  logic                ref_clk_i,
    input  logic                usb_clk_i,
    input  logic                cpu_stop_ni,
    input  logic                pci_stop_ni,
    input  logic                sdr_stop_ni,
    input  logic                pd_ni,
    input  logic                hiz_i,
    input  logic                usb_half_i,
    input  logic [CPU_OUTS-1:0] cpu_en_i,
    input  logic [PCI_OUTS-1:0] pci_en_i,
    input  logic [SDR_OUTS-1:0] sdr_en_i,
    input  logic [REF_OUTS-1:0] ref_en_i,
    input  logic [USB_OUTS-1:0] usb_en_i,
    output logic [CPU_OUTS-1:0] cpu_clk_o,
    output logic [PCI_OUTS-1:0] pci_clk_o,
    output logic [SDR_OUTS-1:0] sdr_clk_o,
    output logic [REF_OUTS-1:0] ref_clk_o,
    output logic [USB_OUTS-1:0] usb_clk_o,
    output logic                clk_oe_o
);

    logic rate_src;
    logic rate_safe;

    clkout_group #(.OUTS(CPU_OUTS), .FREE(CPU_FREE), .HAS_STOP(1'b1)) u_cpu (
        .clk_i   (cpu_clk_i),
        .rst_ni  (rst_ni),
        .src_i   ({CPU_OUTS{cpu_clk_i}}),
        .safe_i  ({CPU_OUTS{1'b1}}),
        .en_i    (cpu_en_i),
        .stop_ni (cpu_stop_ni),
        .pd_ni   (pd_ni),
        .gclk_o  (cpu_clk_o)
    );

    clkout_group #(.OUTS(PCI_OUTS), .FREE(PCI_FREE), .HAS_STOP(1'b1)) u_pci (
        .clk_i   (pci_clk_i),
        .rst_ni  (rst_ni),
        .src_i   ({PCI_OUTS{pci_clk_i}}),
        .safe_i  ({PCI_OUTS{1'b1}}),
        .en_i    (pci_en_i),
        .stop_ni (pci_stop_ni),
        .pd_ni   (pd_ni),
        .gclk_o  (pci_clk_o)
    );

    clkout_group #(.OUTS(SDR_OUTS), .FREE(SDR_FREE), .HAS_STOP(1'b1)) u_sdr (
        .clk_i   (sdr_clk_i),
        .rst_ni  (rst_ni),
        .src_i   ({SDR_OUTS{sdr_clk_i}}),
        .safe_i  ({SDR_OUTS{1'b1}}),
        .en_i    (sdr_en_i),
        .stop_ni (sdr_stop_ni),
        .pd_ni   (pd_ni),
        .gclk_o  (sdr_clk_o)
    );

    clkout_group #(.OUTS(REF_OUTS), .FREE(REF_OUTS), .HAS_STOP(1'b0)) u_ref (
        .clk_i   (ref_clk_i),
        .rst_ni  (rst_ni),
        .src_i   ({REF_OUTS{ref_clk_i}}),
        .safe_i  ({REF_OUTS{1'b1}}),
        .en_i    (ref_en_i),
        .stop_ni (1'b1),
        .pd_ni   (pd_ni),
        .gclk_o  (ref_clk_o)
    );

    clkout_rate_sel u_rate (
        .clk_i  (usb_clk_i),
        .rst_ni (rst_ni),
        .half_i (usb_half_i),
        .src_o  (rate_src),
        .safe_o (rate_safe)
    );

    clkout_group #(.OUTS(USB_OUTS), .FREE(USB_OUTS), .HAS_STOP(1'b0)) u_usb (
        .clk_i   (usb_clk_i),
        .rst_ni  (rst_ni),
        .src_i   ({rate_src, usb_clk_i}),
        .safe_i  ({rate_safe, 1'b1}),
        .en_i    (usb_en_i),
        .stop_ni (1'b1),
        .pd_ni   (pd_ni),
        .gclk_o  (usb_clk_o)
    );

    // high-impedance request wins over every other control
    assign clk_oe_o = ~hiz_i;

endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk
    import clkout_pkg::*;
(
    input logic                rst_ni,
    input logic                cpu_clk_i,
    input logic                pci_clk_i,
    input logic                sdr_clk_i,
    input logic                cpu_stop_ni,
    input logic                pci_stop_ni,
    input logic                sdr_stop_ni,
    input logic                pd_ni,
    input logic [CPU_OUTS-1:0] cpu_en_i,
    input logic [CPU_OUTS-1:0] cpu_clk_o,
    input logic [PCI_OUTS-1:0] pci_clk_o,
    input logic [SDR_OUTS-1:0] sdr_clk_o
);

    // falling edges seen since reset, saturating
    logic [2:0] cpu_age;
    always_ff @(negedge cpu_clk_i or negedge rst_ni) begin
        if (!rst_ni)             cpu_age <= '0;
        else if (cpu_age != 3'd4) cpu_age <= cpu_age + 3'd1;
    end

    // sampled on falling edges, the output value seen is its high-phase level
    for (genvar g = 0; g < CPU_OUTS; g++) begin : g_cpu
        p_cpu_disabled_low_r4: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
            (!cpu_en_i[g] && !$past(cpu_en_i[g]) && !$past(cpu_en_i[g], 2) && !$past(cpu_en_i[g], 3))
            |-> !cpu_clk_o[g]);

        if (g >= CPU_FREE) begin : g_stoppable
            p_cpu_stopped_low_r1: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
                (!cpu_stop_ni && !$past(cpu_stop_ni) && !$past(cpu_stop_ni, 2) && !$past(cpu_stop_ni, 3))
                |-> !cpu_clk_o[g]);
        end else begin : g_free
            p_cpu_free_runs_r1: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
                (cpu_age == 3'd4 && cpu_en_i[g] && $past(cpu_en_i[g]) && $past(cpu_en_i[g], 2)
                 && $past(cpu_en_i[g], 3) && pd_ni && $past(pd_ni) && $past(pd_ni, 2) && $past(pd_ni, 3))
                |-> cpu_clk_o[g]);
        end
    end

    p_pd_all_low_r5: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
        (!pd_ni && !$past(pd_ni) && !$past(pd_ni, 2) && !$past(pd_ni, 3)) |-> (cpu_clk_o == '0));

    for (genvar g = PCI_FREE; g < PCI_OUTS; g++) begin : g_pci
        p_pci_stopped_low_r2: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
            (!pci_stop_ni && !$past(pci_stop_ni) && !$past(pci_stop_ni, 2) && !$past(pci_stop_ni, 3))
            |-> !pci_clk_o[g]);
    end

    for (genvar g = SDR_FREE; g < SDR_OUTS; g++) begin : g_sdr
        p_sdr_stopped_low_r3: assert property (@(negedge sdr_clk_i) disable iff (!rst_ni)
            (!sdr_stop_ni && !$past(sdr_stop_ni) && !$past(sdr_stop_ni, 2) && !$past(sdr_stop_ni, 3))
            |-> !sdr_clk_o[g]);
    end

endmodule

bind clkout_gate clkout_gate_chk i_chk (
    .rst_ni      (rst_ni),
    .cpu_clk_i   (cpu_clk_i),
    .pci_clk_i   (pci_clk_i),
    .sdr_clk_i   (sdr_clk_i),
    .cpu_stop_ni (cpu_stop_ni),
    .pci_stop_ni (pci_stop_ni),
    .sdr_stop_ni (sdr_stop_ni),
    .pd_ni       (pd_ni),
    .cpu_en_i    (cpu_en_i),
    .cpu_clk_o   (cpu_clk_o),
    .pci_clk_o   (pci_clk_o),
    .sdr_clk_o   (sdr_clk_o)
);

// File: tb/test_clkout_gate.sv
`timescale 1ns/1ps

module pulse_watch #(
    parameter real MIN_HI = 1.0
) (
    input  logic sig,
    input  logic clr,
    output int   rises_o,
    output int   runts_o
);
    realtime t_up;
    bit      seen;

    always @(posedge sig or posedge clr) begin
        if (clr) rises_o = 0;
        else begin
            rises_o = rises_o + 1;
            t_up    = $realtime;
            seen    = 1'b1;
        end
    end

    always @(negedge sig) begin
        if (seen && (($realtime - t_up) < (MIN_HI - 0.01))) runts_o = runts_o + 1;
    end
endmodule

module test_clkout_gate;

    logic clk = 1'b0, pci = 1'b0, sdr = 1'b0, refc = 1'b0, usb = 1'b0;
    always #10   clk  = ~clk;
    always #15   pci  = ~pci;
    always #7.5  sdr  = ~sdr;
    always #35   refc = ~refc;
    always #10.5 usb  = ~usb;

    logic        rst_n = 1'b0;
    logic        cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sdr_stop_n = 1'b1, pd_n = 1'b1;
    logic        hiz = 1'b0, usb_half = 1'b1;
    logic [2:0]  cpu_en = '1;
    logic [6:0]  pci_en = '1;
    logic [9:0]  sdr_en = '1;
    logic [1:0]  ref_en = '1;
    logic [1:0]  usb_en = '1;
    logic [2:0]  cpu_o;
    logic [6:0]  pci_o;
    logic [9:0]  sdr_o;
    logic [1:0]  ref_o;
    logic [1:0]  usb_o;
    logic        oe;
    logic        clr = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    clkout_gate i_clkout_gate (
        .rst_ni(rst_n), .cpu_clk_i(clk), .pci_clk_i(pci), .sdr_clk_i(sdr),
        .ref_clk_i(refc), .usb_clk_i(usb), .cpu_stop_ni(cpu_stop_n),
        .pci_stop_ni(pci_stop_n), .sdr_stop_ni(sdr_stop_n), .pd_ni(pd_n),
        .hiz_i(hiz), .usb_half_i(usb_half), .cpu_en_i(cpu_en), .pci_en_i(pci_en),
        .sdr_en_i(sdr_en), .ref_en_i(ref_en), .usb_en_i(usb_en),
        .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .sdr_clk_o(sdr_o),
        .ref_clk_o(ref_o), .usb_clk_o(usb_o), .clk_oe_o(oe)
    );

    // bits: 0-2 processor, 3-9 PCI, 10-19 SDRAM, 20-21 reference, 22-23 peripheral
    wire [23:0] all_o = {usb_o, ref_o, sdr_o, pci_o, cpu_o};
    int rises [24];
    int runts [24];

    for (genvar g = 0; g < 24; g++) begin : g_mon
        localparam real HALF = (g < 3) ? 10.0 : (g < 10) ? 15.0 : (g < 20) ? 7.5 : (g < 22) ? 35.0 : 10.5;
        pulse_watch #(.MIN_HI(HALF)) u_w (.sig(all_o[g]), .clr(clr), .rises_o(rises[g]), .runts_o(runts[g]));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear();
        clr = 1'b1;
        #0.5;
        clr = 1'b0;
    endtask

    task automatic defaults();
        cpu_stop_n = 1; pci_stop_n = 1; sdr_stop_n = 1; pd_n = 1; hiz = 0; usb_half = 1;
        cpu_en = '1; pci_en = '1; sdr_en = '1; ref_en = '1; usb_en = '1;
    endtask

    function automatic bit exp_on(int b);
        bit en, stp, fr;
        if (b < 3)       begin en = cpu_en[b];      stp = cpu_stop_n; fr = (b < 1);       end
        else if (b < 10) begin en = pci_en[b-3];    stp = pci_stop_n; fr = (b - 3 < 1);   end
        else if (b < 20) begin en = sdr_en[b-10];   stp = sdr_stop_n; fr = (b - 10 < 2);  end
        else if (b < 22) begin en = ref_en[b-20];   stp = 1'b1;       fr = 1'b1;          end
        else             begin en = usb_en[b-22];   stp = 1'b1;       fr = 1'b1;          end
        return pd_n && en && (stp || fr);
    endfunction

    function automatic string tag_of(int b);
        if (!pd_n) return "R5 power-down";
        if (b < 3)  return exp_on(b) ? "R1 cpu running" : (cpu_en[b] ? "R1 cpu stopped" : "R4 cpu disabled");
        if (b < 10) return exp_on(b) ? "R2 pci running" : (pci_en[b-3] ? "R2 pci stopped" : "R4 pci disabled");
        if (b < 20) return exp_on(b) ? "R3 sdram running" : (sdr_en[b-10] ? "R3 sdram stopped" : "R4 sdram disabled");
        return exp_on(b) ? "R4 peripheral enabled" : "R4 peripheral disabled";
    endfunction

    task automatic run_phase();
        #300;
        clear();
        #400;
        for (int b = 0; b < 24; b++) begin
            if (exp_on(b)) chk(rises[b] >= 3, tag_of(b), rises[b], 3);
            else           chk(rises[b] == 0, tag_of(b), rises[b], 0);
        end
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R10: outputs low under reset
        #50;
        chk(all_o == '0, "R10 reset", int'(all_o), 0);
        chk(oe == 1'b1, "R6 oe idle", int'(oe), 1);
        #53;
        rst_n = 1'b1;

        // R1 / R4 sweep over processor stop and all enable patterns
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 8; e++) begin
                defaults(); cpu_stop_n = s[0]; cpu_en = e[2:0];
                run_phase();
            end
        end
        // R2 walking-zero enables with and without stop
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                defaults(); pci_stop_n = s[0];
                pci_en = (k == 7) ? 7'h7f : ~(7'h1 << k);
                run_phase();
            end
        end
        // R3 walking-zero enables with and without stop
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 11; k++) begin
                defaults(); sdr_stop_n = s[0];
                sdr_en = (k == 10) ? 10'h3ff : ~(10'h1 << k);
                run_phase();
            end
        end
        // R4 reference and peripheral enables, with all group stops asserted
        for (int e = 0; e < 16; e++) begin
            defaults(); cpu_stop_n = 0; pci_stop_n = 0; sdr_stop_n = 0;
            {usb_en, ref_en} = e[3:0];
            run_phase();
        end
        // R5 power-down beats everything
        defaults(); pd_n = 0;
        run_phase();
        defaults(); pd_n = 0; cpu_stop_n = 0; sdr_stop_n = 0;
        run_phase();

        // R9 rate selection
        defaults(); usb_half = 1'b1;
        run_phase();
        chk((rises[23] * 2 - rises[22]) <= 2 && (rises[22] - rises[23] * 2) <= 2,
            "R9 half rate", rises[23], rises[22] / 2);
        defaults(); usb_half = 1'b0;
        run_phase();
        chk((rises[23] - rises[22]) <= 1 && (rises[22] - rises[23]) <= 1,
            "R9 full rate", rises[23], rises[22]);

        // R6 high-impedance request, with power-down also asserted
        defaults(); hiz = 1'b1; pd_n = 1'b0;
        #1;
        chk(oe == 1'b0, "R6 hiz with pd", int'(oe), 0);
        pd_n = 1'b1;
        #1;
        chk(oe == 1'b0, "R6 hiz", int'(oe), 0);
        hiz = 1'b0;
        #1;
        chk(oe == 1'b1, "R6 hiz released", int'(oe), 1);

        // R8 edge-exact latency on processor bit 1
        defaults();
        #300;
        @(posedge clk); #3;
        cpu_stop_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        clear();
        repeat (5) @(posedge clk);
        #1;
        chk(rises[1] == 0, "R8 stop latency", rises[1], 0);
        chk(rises[0] == 5, "R8 free output during stop", rises[0], 5);
        @(posedge clk); #3;
        cpu_stop_n = 1'b1;
        clear();
        repeat (3) @(posedge clk);
        #1;
        chk(rises[1] == 1, "R8 release latency", rises[1], 1);

        // R7 stress: controls change at every offset inside the processor period
        defaults();
        for (int off = 0; off < 20; off++) begin
            @(posedge clk); #(off + 0.5);
            cpu_stop_n = ~cpu_stop_n;
            cpu_en[2]  = ~cpu_en[2];
            sdr_stop_n = ~sdr_stop_n;
            pci_en[3]  = ~pci_en[3];
            usb_half   = ~usb_half;
            if (off % 5 == 4) pd_n = ~pd_n;
            repeat (2) @(posedge clk);
        end
        defaults();
        #500;
        for (int b = 0; b < 24; b++) chk(runts[b] == 0, "R7 runt pulse", runts[b], 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule